// File: doc/BRIEF.md
# Fine DAC Step Accumulator

This block keeps the 12-bit code for a fine DAC stage and two 8-bit coarse reference codes (a high one and a low one) that bound that stage. Software or a control sequencer loads the fine code, the step magnitude and the coarse pair through dedicated write ports. Outside logic can then nudge the fine code without any register traffic. Each rising edge on an asynchronous step strobe moves the fine code by the stored magnitude. A separate asynchronous direction pin picks whether the move is up or down.

Both asynchronous pins pass through a two-flop synchroniser. A rising-edge detector follows. The step is applied on the clock edge after the detector fires. The result clamps at the ends of the 12-bit range and never wraps. A direct write to the fine code in the same cycle as a step takes precedence. The analog stages fed by these codes sit outside this block.

Top module: `dacstep_accum`

## Requirements
- R1: While `rst` is high at a clock edge, every stored value (fine code, step magnitude, coarse high and coarse low) becomes 0. All outputs read 0 after reset is released.
- R2: When `fine_we_i` is 1 at a clock edge, `fine_code_o` equals `fine_wdata_i` from that edge onward.
- R3: If `step_strobe_i` rises between two clock edges and `step_up_i` is 1, `fine_code_o` keeps its old value after the first and second following edges. It becomes old value plus step magnitude after the third following edge.
- R4: With `step_up_i` = 0, a strobe rise lowers `fine_code_o` by the step magnitude, with the same three-edge timing as R3.
- R5: A step up whose sum would exceed 0xFFF leaves `fine_code_o` at 0xFFF.
- R6: A step down by more than the current code leaves `fine_code_o` at 0.
- R7: Each low-to-high transition of the strobe causes exactly one step. Holding the strobe high or low for any number of cycles causes no further change.
- R8: The direction used for a step is the level of `step_up_i` (1 = up, 0 = down). It passes through the same two-flop synchroniser as the strobe, so a direction set together with the strobe rise applies to that step.
- R9: If `fine_we_i` is 1 on the edge where a detected step would be applied, the written value is stored and the step is discarded.
- R10: When `step_we_i` is 1 at a clock edge, `step_wdata_i` becomes the magnitude for all later steps. A magnitude of 0 leaves the fine code unchanged on a step.
- R11: When `coarse_we_i` is 1 at a clock edge, `coarse_hi_o` takes `coarse_wdata_i[15:8]` and `coarse_lo_o` takes `coarse_wdata_i[7:0]`.
- R12: Steps and fine-code writes never change the coarse outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_strobe_i | input | 1 | Asynchronous step request; each rising edge requests one step |
| step_up_i | input | 1 | Asynchronous direction: 1 adds the step, 0 subtracts it |
| fine_we_i | input | 1 | Write enable for the fine code |
| fine_wdata_i | input | 12 | New fine code |
| step_we_i | input | 1 | Write enable for the step magnitude |
| step_wdata_i | input | 12 | New unsigned step magnitude |
| coarse_we_i | input | 1 | Write enable for the coarse pair |
| coarse_wdata_i | input | 16 | Coarse pair: high code in bits 15:8, low code in bits 7:0 |
| fine_code_o | output | 12 | Current fine DAC code |
| coarse_hi_o | output | 8 | Current high coarse reference code |
| coarse_lo_o | output | 8 | Current low coarse reference code |

## Verification
The hardest situation to reach is a fine-code write that lands on exactly the edge where a synchronised step is applied. The step only arrives three edges after the pin moves, so the stimulus counts clock edges from the strobe rise and asserts the write on the third one. The saturation corners need the accumulated code close to a rail. Random sequences therefore mix large step magnitudes and preloaded codes near 0 and 0xFFF, and directed cases clamp at both ends. A strobe held high for many cycles shows that a single transition yields a single step.

// File: rtl/dacstep_pkg.sv
package dacstep_pkg;

    parameter int FINE_W     = 12;
    parameter int CRS_W      = 8;
    parameter int SYNC_DEPTH = 2;

    localparam int CRS_PAIR_W = 2 * CRS_W;

    typedef logic [FINE_W-1:0] fine_code_t;
    typedef logic [CRS_W-1:0]  crs_code_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_req_t;

    // high code in the upper half so the packed layout matches the write word
    typedef struct packed {
        crs_code_t hi;
        crs_code_t lo;
    } crs_pair_t;

    function automatic fine_code_t clamp_step(fine_code_t cur, fine_code_t mag, step_dir_e dir);
        logic [FINE_W:0] sum;
        if (dir == DIR_UP) begin
            sum = {1'b0, cur} + {1'b0, mag};
            return sum[FINE_W] ? {FINE_W{1'b1}} : sum[FINE_W-1:0];
        end
        if (mag > cur) begin
            return '0;
        end
        return cur - mag;
    endfunction

endpackage

// File: rtl/dacstep_sync.sv
module dacstep_sync #(
    parameter int W      = 2,
    parameter int STAGES = dacstep_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/dacstep_edge.sv
module dacstep_edge
    import dacstep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_s,
    input  logic      up_s,
    output step_req_t req
);
    logic strobe_prev_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_prev_q <= 1'b0;
        else     strobe_prev_q <= strobe_s;
    end

    always_comb begin
        req.valid = strobe_s & ~strobe_prev_q;
        req.dir   = up_s ? DIR_UP : DIR_DOWN;
    end

    AST_ONE_PULSE_PER_RISE: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> !req.valid); // R7
endmodule

// File: rtl/dacstep_fine.sv
module dacstep_fine
    import dacstep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  step_req_t  req,
    input  logic       fine_we,
    input  fine_code_t fine_wdata,
    input  logic       step_we,
    input  fine_code_t step_wdata,
    output fine_code_t fine_q
);
    fine_code_t step_mag_q;
    fine_code_t fine_d;

    always_ff @(posedge clk) begin
        if (rst)          step_mag_q <= '0;
        else if (step_we) step_mag_q <= step_wdata;
    end

    always_comb begin
        fine_d = fine_q;
        if (fine_we)        fine_d = fine_wdata;
        else if (req.valid) fine_d = clamp_step(fine_q, step_mag_q, req.dir);
    end

    always_ff @(posedge clk) begin
        if (rst) fine_q <= '0;
        else     fine_q <= fine_d;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        fine_we |=> fine_q == $past(fine_wdata)); // R9
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.dir == DIR_UP && !fine_we) |=> fine_q >= $past(fine_q)); // R5
    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.dir == DIR_DOWN && !fine_we) |=> fine_q <= $past(fine_q)); // R6
    AST_FINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!req.valid && !fine_we) |=> $stable(fine_q)); // R7
endmodule

// File: rtl/dacstep_coarse.sv
module dacstep_coarse
    import dacstep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  crs_pair_t wr_pair,
    output crs_pair_t pair_q
);
    always_ff @(posedge clk) begin
        if (rst)        pair_q <= '0;
        else if (wr_en) pair_q <= wr_pair;
    end

    AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pair_q)); // R12
endmodule

// File: rtl/dacstep_accum.sv
module dacstep_accum
    import dacstep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_strobe_i,
    input  logic                  step_up_i,
    input  logic                  fine_we_i,
    input  logic [FINE_W-1:0]     fine_wdata_i,
    input  logic                  step_we_i,
    input  logic [FINE_W-1:0]     step_wdata_i,
    input  logic                  coarse_we_i,
    input  logic [CRS_PAIR_W-1:0] coarse_wdata_i,
    output logic [FINE_W-1:0]     fine_code_o,
    output logic [CRS_W-1:0]      coarse_hi_o,
    output logic [CRS_W-1:0]      coarse_lo_o
);
    logic [1:0] pins_s;
    step_req_t  req;
    crs_pair_t  crs_q;

    dacstep_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({step_up_i, step_strobe_i}),
        .q_sync  (pins_s)
    );

    dacstep_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_s (pins_s[0]),
        .up_s     (pins_s[1]),
        .req      (req)
    );

    dacstep_fine u_fine (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .fine_we    (fine_we_i),
        .fine_wdata (fine_wdata_i),
        .step_we    (step_we_i),
        .step_wdata (step_wdata_i),
        .fine_q     (fine_code_o)
    );

    dacstep_coarse u_coarse (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coarse_we_i),
        .wr_pair (crs_pair_t'(coarse_wdata_i)),
        .pair_q  (crs_q)
    );

    assign coarse_hi_o = crs_q.hi;
    assign coarse_lo_o = crs_q.lo;
endmodule

// File: tb/dacstep_accum_tb.sv
`timescale 1ns/1ps
module dacstep_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        step_strobe_i, step_up_i;
    logic        fine_we_i, step_we_i, coarse_we_i;
    logic [11:0] fine_wdata_i, step_wdata_i;
    logic [15:0] coarse_wdata_i;
    logic [11:0] fine_code_o;
    logic [7:0]  coarse_hi_o, coarse_lo_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [11:0] m_fine, m_step;
    logic [7:0]  m_hi, m_lo;

    always #2 clk = ~clk;

    dacstep_accum dut_i (.*);

    function automatic logic [11:0] exp_step(logic [11:0] cur, logic [11:0] mag, bit up);
        int v;
        if (up) v = int'(cur) + int'(mag);
        else    v = int'(cur) - int'(mag);
        if (v > 4095) v = 4095;
        if (v < 0)    v = 0;
        return v[11:0];
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        check(req, {4'h0, fine_code_o}, {4'h0, m_fine});
        check(req, {8'h0, coarse_hi_o}, {8'h0, m_hi});
        check(req, {8'h0, coarse_lo_o}, {8'h0, m_lo});
    endtask

    task automatic wr_fine(logic [11:0] v);
        @(negedge clk); fine_we_i = 1; fine_wdata_i = v;
        @(negedge clk); fine_we_i = 0;
        m_fine = v;
        check("R2", {4'h0, fine_code_o}, {4'h0, v});
    endtask

    task automatic wr_step(logic [11:0] v);
        @(negedge clk); step_we_i = 1; step_wdata_i = v;
        @(negedge clk); step_we_i = 0;
        m_step = v;
    endtask

    task automatic wr_coarse(logic [15:0] v);
        @(negedge clk); coarse_we_i = 1; coarse_wdata_i = v;
        @(negedge clk); coarse_we_i = 0;
        m_hi = v[15:8]; m_lo = v[7:0];
        check("R11", {8'h0, coarse_hi_o}, {8'h0, m_hi});
        check("R11", {8'h0, coarse_lo_o}, {8'h0, m_lo});
    endtask

    task automatic do_step(bit up, string req);
        @(negedge clk); step_strobe_i = 1; step_up_i = up;
        @(negedge clk);
        @(negedge clk);
        check("R3 timing", {4'h0, fine_code_o}, {4'h0, m_fine});
        @(negedge clk);
        m_fine = exp_step(m_fine, m_step, up);
        check(req, {4'h0, fine_code_o}, {4'h0, m_fine});
        step_strobe_i = 0;
        repeat (3) @(negedge clk);
        check_all("R12");
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; step_strobe_i = 0; step_up_i = 0;
        fine_we_i = 0; step_we_i = 0; coarse_we_i = 0;
        fine_wdata_i = 0; step_wdata_i = 0; coarse_wdata_i = 0;
        m_fine = 0; m_step = 0; m_hi = 0; m_lo = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all("R1");
        do_step(1, "R1 step zero");

        // directed corners
        wr_coarse(16'hA53C);
        wr_step(12'd100);
        wr_fine(12'd1000);
        do_step(1, "R3");
        do_step(0, "R4");
        wr_step(12'd0);
        do_step(1, "R10 zero step");
        wr_step(12'd300);
        wr_fine(12'hF00);
        do_step(1, "R5");
        check("R5", {4'h0, fine_code_o}, 16'h0FFF);
        wr_fine(12'd50);
        do_step(0, "R6");
        check("R6", {4'h0, fine_code_o}, 16'h0000);
        wr_fine(12'd600);
        do_step(0, "R8 down");
        do_step(1, "R8 up");

        // strobe held high: one step only
        @(negedge clk); step_strobe_i = 1; step_up_i = 1;
        repeat (12) @(negedge clk);
        m_fine = exp_step(m_fine, m_step, 1);
        check("R7 held high", {4'h0, fine_code_o}, {4'h0, m_fine});
        step_strobe_i = 0;
        repeat (12) @(negedge clk);
        check("R7 held low", {4'h0, fine_code_o}, {4'h0, m_fine});

        // write on the edge where the step lands
        @(negedge clk); step_strobe_i = 1; step_up_i = 1;
        @(negedge clk);
        @(negedge clk); fine_we_i = 1; fine_wdata_i = 12'h123;
        @(negedge clk); fine_we_i = 0;
        m_fine = 12'h123;
        check("R9", {4'h0, fine_code_o}, 16'h0123);
        step_strobe_i = 0;
        repeat (4) @(negedge clk);
        check("R9 no late step", {4'h0, fine_code_o}, 16'h0123);
        check_all("R12");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int act;
            act = $urandom_range(0, 9);
            if (act == 0)      wr_fine(($urandom_range(0, 1) == 1) ? 12'($urandom_range(4000, 4095)) : 12'($urandom_range(0, 90)));
            else if (act == 1) wr_fine(12'($urandom));
            else if (act == 2) wr_step(($urandom_range(0, 3) == 0) ? 12'($urandom_range(2000, 4095)) : 12'($urandom_range(0, 200)));
            else if (act == 3) wr_coarse(16'($urandom));
            else               do_step(1'($urandom_range(0, 1)), "R3/R4/R5/R6 random");
        end

        check_all("R12 final");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule